// File: doc/BRIEF.md
# Maskable Clear-On-Read Interrupt Status Word

This block gathers seven interrupt sources into one 8-bit status word that a host polls or services from an interrupt line. Five sources arrive as single-cycle event pulses. Two arrive as level status signals, a one-second flag and a five-second flag. For each of those two levels, only its rising edge counts as an event. Each source has its own mask bit. An event whose mask bit is clear sets its status bit. The bit then stays set until the host reads the word.

A read is a one-cycle strobe. During the strobe cycle the status port still shows the held value, so the host samples it there. On the following clock edge every pending bit clears. An event that arrives in the same cycle as the read is not lost: it is pending after the clear. The interrupt line is high whenever any status bit is set. All pins are plain control and status pins. There is no data stream and no handshake.

Top module: `irq_status_word`

## Requirements
- R1: The status bits are laid out as follows: bit 0 signalling change, bit 1 bit-oriented message, bit 2 five-second rising edge, bit 3 one-second rising edge, bit 4 loop code detected, bit 5 HDLC1 event, bit 6 HDLC0 event. Bit 7 always reads 0.
- R2: An unmasked event sets its status bit at the clock edge that samples it. The bit stays set while no read occurs.
- R3: The mask bit for a source is irq_mask[n], where n is that source's status bit position. If the mask bit is 1, an event from that source leaves its status bit unchanged.
- R4: Status bit 3 sets only when sec1_lvl goes from low to high. Holding the level high, or dropping it, does not set the bit again.
- R5: Status bit 2 sets only when sec5_lvl goes from low to high. Holding the level high, or dropping it, does not set the bit again.
- R6: While rd_stb is high, status shows the value held before the read. On the clock edge that samples rd_stb, every pending bit clears.
- R7: An unmasked event that is sampled on the same edge as rd_stb is set after that edge.
- R8: irq is high exactly when any status bit is set.
- R9: A level that is already high when reset is released produces no event.
- R10: Reset clears every status bit and drives irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdlc0_evt | input | 1 | HDLC0 event pulse |
| hdlc1_evt | input | 1 | HDLC1 event pulse |
| loop_evt | input | 1 | Loop code detected pulse |
| bom_evt | input | 1 | Bit-oriented message pulse |
| sig_evt | input | 1 | Signalling change pulse |
| sec1_lvl | input | 1 | One-second status level |
| sec5_lvl | input | 1 | Five-second status level |
| irq_mask | input | 7 | Per-source mask, 1 blocks the source |
| rd_stb | input | 1 | Host read strobe, clears on its edge |
| status | output | 8 | Pending status word |
| irq | output | 1 | OR of all pending bits |

## Verification
Each pulse or rising level that is sampled on clock edge N appears in status right after edge N. The same holds for a read clear. The interrupt line follows status combinationally, with no extra cycle. The bench drives inputs on the falling edge and samples 1 ns after the rising edge that makes each result due. It reads the pre-clear value during the strobe cycle, before that rising edge. A level source is held low for a full idle cycle between stimuli, so the edge detector has seen the low level before the next rise is due.

// File: rtl/irq_word_pkg.sv
package irq_word_pkg;
  localparam int WORD_W  = 8;
  localparam int NUM_SRC = WORD_W - 1;

  // bit positions inside the status word
  localparam int POS_SIG   = 0;
  localparam int POS_BOM   = 1;
  localparam int POS_SEC5  = 2;
  localparam int POS_SEC1  = 3;
  localparam int POS_LOOP  = 4;
  localparam int POS_HDLC1 = 5;
  localparam int POS_HDLC0 = 6;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_rise_detect.sv
module irq_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;
  logic armed_q;

  // first cycle after reset only records the level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      armed_q <= 1'b1;
    end
  end

  assign rise_o = armed_q & lvl_i & ~prev_q;

  AST_RISE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> (lvl_i && !$past(lvl_i))); // R4
  AST_HIGH_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lvl_i) && $past(rst_n)) |-> !rise_o); // R5
endmodule

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic q_o
);
  logic hit;
  logic q_d;

  assign hit = evt_i & ~mask_i;

  always_comb begin
    if (clr_i) q_d = hit;
    else       q_d = q_o | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end

  AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !mask_i) |=> q_o); // R2
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && (mask_i || !evt_i)) |=> $stable(q_o)); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(evt_i && !mask_i)) |=> !q_o); // R6
endmodule

// File: rtl/irq_status_word.sv
module irq_status_word
  import irq_word_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hdlc0_evt,
  input  logic               hdlc1_evt,
  input  logic               loop_evt,
  input  logic               bom_evt,
  input  logic               sig_evt,
  input  logic               sec1_lvl,
  input  logic               sec5_lvl,
  input  logic [NUM_SRC-1:0] irq_mask,
  input  logic               rd_stb,
  output logic [WORD_W-1:0]  status,
  output logic               irq
);
  logic     sec1_rise;
  logic     sec5_rise;
  src_vec_t evt_vec;
  src_vec_t pend;

  irq_rise_detect u_sec1_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(sec1_lvl), .rise_o(sec1_rise)
  );
  irq_rise_detect u_sec5_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(sec5_lvl), .rise_o(sec5_rise)
  );

  always_comb begin
    evt_vec            = '0;
    evt_vec[POS_SIG]   = sig_evt;
    evt_vec[POS_BOM]   = bom_evt;
    evt_vec[POS_SEC5]  = sec5_rise;
    evt_vec[POS_SEC1]  = sec1_rise;
    evt_vec[POS_LOOP]  = loop_evt;
    evt_vec[POS_HDLC1] = hdlc1_evt;
    evt_vec[POS_HDLC0] = hdlc0_evt;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    irq_sticky_bit u_bit (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_vec[i]), .mask_i(irq_mask[i]),
      .clr_i(rd_stb), .q_o(pend[i])
    );
  end

  assign status = {{(WORD_W-NUM_SRC){1'b0}}, pend};
  assign irq    = |pend;

  AST_IRQ_DROPS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && ((evt_vec & ~irq_mask) == '0)) |=> !irq); // R8
  AST_IRQ_RISES_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_vec & ~irq_mask) != '0) |=> irq); // R8
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status[WORD_W-1] == 1'b0)); // R1
endmodule

// File: tb/irq_status_word_bench.sv
module irq_status_word_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hdlc0_evt = 1'b0, hdlc1_evt = 1'b0, loop_evt = 1'b0;
  logic       bom_evt = 1'b0, sig_evt = 1'b0;
  logic       sec1_lvl = 1'b0, sec5_lvl = 1'b0;
  logic [6:0] irq_mask = 7'h00;
  logic       rd_stb = 1'b0;
  logic [7:0] status;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_status_word u_irq_status_word (
    .clk(clk), .rst_n(rst_n), .hdlc0_evt(hdlc0_evt), .hdlc1_evt(hdlc1_evt),
    .loop_evt(loop_evt), .bom_evt(bom_evt), .sig_evt(sig_evt),
    .sec1_lvl(sec1_lvl), .sec5_lvl(sec5_lvl), .irq_mask(irq_mask),
    .rd_stb(rd_stb), .status(status), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input logic [7:0] exp);
    chk(status === exp, req, status, exp);
    chk(irq === (exp != 8'h00), {req, " irq R8"}, irq, exp != 8'h00);
  endtask

  // b[n] drives the source of status bit n; bits 2 and 3 raise the levels
  task automatic fire(input logic [6:0] b, input bit rd);
    @(negedge clk);
    sig_evt = b[0]; bom_evt = b[1]; sec5_lvl = b[2]; sec1_lvl = b[3];
    loop_evt = b[4]; hdlc1_evt = b[5]; hdlc0_evt = b[6]; rd_stb = rd;
    @(posedge clk); #1;
    {sig_evt, bom_evt, sec5_lvl, sec1_lvl, loop_evt, hdlc1_evt, hdlc0_evt} = '0;
    rd_stb = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic host_read(input logic [7:0] exp_before);
    @(negedge clk);
    rd_stb = 1'b1;
    #1 chk(status === exp_before, "R6 pre-clear value", status, exp_before);
    @(posedge clk); #1;
    rd_stb = 1'b0;
    chk_word("R6 cleared", 8'h00);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  initial begin
    // R9: levels high through reset release
    sec1_lvl = 1'b1; sec5_lvl = 1'b1;
    #23;
    chk_word("R10 reset state", 8'h00);
    rst_n = 1'b1;
    idle(3);
    chk_word("R9 no wake event", 8'h00);
    @(negedge clk); sec1_lvl = 1'b0; sec5_lvl = 1'b0;
    idle(2);
    chk_word("R4 falling no set", 8'h00);

    // R1 R2: each source alone lands on its own bit
    for (int s = 0; s < 7; s++) begin
      fire(7'(1 << s), 1'b0);
      chk_word("R1 R2 single source", 8'(1 << s));
      idle(2);
      chk_word("R2 stays set", 8'(1 << s));
      host_read(8'(1 << s));
    end

    // R3: sweep every mask pattern with all sources firing
    for (int m = 0; m < 128; m++) begin
      irq_mask = 7'(m);
      fire(7'h7F, 1'b0);
      chk_word("R3 mask sweep", {1'b0, ~7'(m)});
      host_read({1'b0, ~7'(m)});
    end
    irq_mask = 7'h00;

    // R4 R5: only the rising edge of each level counts
    for (int j = 0; j < 2; j++) begin
      logic [7:0] bitv;
      bitv = (j == 0) ? 8'h08 : 8'h04;
      @(negedge clk);
      if (j == 0) sec1_lvl = 1'b1; else sec5_lvl = 1'b1;
      @(posedge clk); #1;
      chk_word(j == 0 ? "R4 rise sets" : "R5 rise sets", bitv);
      host_read(bitv);
      idle(3);
      chk_word(j == 0 ? "R4 held high" : "R5 held high", 8'h00);
      @(negedge clk); sec1_lvl = 1'b0; sec5_lvl = 1'b0;
      idle(2);
      chk_word(j == 0 ? "R4 fall" : "R5 fall", 8'h00);
    end

    // R7: event together with read survives, older bit clears
    fire(7'h04, 1'b0);
    chk_word("R2 before coincident read", 8'h04);
    fire(7'h21, 1'b1);
    chk_word("R7 coincident event kept", 8'h21);
    host_read(8'h21);

    // R7 with a level edge on the read cycle
    fire(7'h08, 1'b1);
    chk_word("R7 level edge with read", 8'h08);

    // R10: reset drops pending bits
    fire(7'h50, 1'b0);
    chk_word("R2 pending before reset", 8'h58);
    @(negedge clk); rst_n = 1'b0;
    #2 chk_word("R10 reset clears", 8'h00);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk_word("R10 after reset", 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule